// File: doc/BRIEF.md
# Banked Register Access Unit

This unit holds the banked copies of processor registers that belong to the exception modes, and it serves privileged move-to and move-from accesses that reach the copy owned by a mode other than the one the processor is running in. An access names the current mode, the target mode and a register number. A read strobe returns the selected copy on the read-data output in the same cycle. A write strobe updates the selected copy on the next clock edge.

Every access is screened before it touches storage. The screen looks at the current mode, the target mode and the register number together. An access that fails the screen pulses the undefined-instruction output in the cycle of the strobe. It returns zero on the read-data output and leaves all storage untouched. Register numbers 8 to 12 map to the high general registers, 13 to the stack pointer, 14 to the link register, 16 to the saved status register and 17 to the single Hyp exception-link register.

Top module: `banked_reg_unit`

## Requirements
- R1: An access whose target mode equals the current mode faults.
- R2: With target User, registers 8 to 12 are reachable only while the current mode is FIQ. From any other mode the access faults.
- R3: With target User, register 13 faults from System, and register 14 faults from Hyp or from System.
- R4: With target Hyp, register 17 is reachable from Hyp or Monitor (Hyp itself is then refused by R1). Every other register with target Hyp is reachable only from Monitor.
- R5: The following also fault:
  - a target that is not a defined mode (User 0x10, FIQ 0x11, IRQ 0x12, Supervisor 0x13, Monitor 0x16, Abort 0x17, Hyp 0x1A, Undefined 0x1B, System 0x1F);
  - a register number outside 8 to 17, or equal to 15;
  - registers 8 to 12 with a target other than User or FIQ;
  - register 16 with target User or System;
  - register 17 with a target other than Hyp.
- R6: Register 16 selects the saved status register of the target mode's bank. Register 17 selects one Hyp exception-link register that is shared by every access.
- R7: Registers 13 and 14 select the copy of the target mode's bank. Each exception mode has its own bank, and User and System share one bank.
- R8: Registers 8 to 12 have one User copy and one FIQ copy. The target mode picks the copy, and the element is the register number minus 8.
- R9: A faulting write changes no storage. A faulting read returns zero. The fault output is high in the same cycle as the strobe.
- R10: A valid write takes effect at the clock edge, and a read in that same cycle still returns the old value. With no strobe, the read data is zero and the fault output is low.
- R11: Reset clears every banked copy to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_mode | input | 5 | Mode the processor runs in |
| tgt_mode | input | 5 | Mode whose banked copy is addressed |
| reg_num | input | 5 | Register number, 8 to 17 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | DW | Value to write |
| rd_data | output | DW | Selected copy, zero if no valid read |
| undef_pulse | output | 1 | Undefined-instruction fault for this cycle's access |

## Verification
The assertions check on every cycle that the fault rules hold at the ports:
- a same-mode access faults;
- User high registers are refused outside FIQ;
- targets in Hyp need Monitor;
- an idle cycle never faults;
- a fault always reads zero;
- a faulting write never enables storage.

Only the bench's scenarios can show that values land in the right copy. They check that distinct banks stay apart, that User and System alias, that the two high-register copies are separate, and that a refused write leaves the earlier contents readable afterwards.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_MON = 5'h16;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_HYP = 5'h1A;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  localparam int NBANK  = 8;
  localparam int BANK_W = $clog2(NBANK);

  localparam logic [4:0] RN_HI_LO = 5'd8;
  localparam logic [4:0] RN_HI_HI = 5'd12;
  localparam logic [4:0] RN_SP    = 5'd13;
  localparam logic [4:0] RN_LR    = 5'd14;
  localparam logic [4:0] RN_SPSR  = 5'd16;
  localparam logic [4:0] RN_ELR   = 5'd17;

  // Bank slot of a mode; User and System share slot 0
  function automatic logic [BANK_W-1:0] bank_of(input logic [4:0] m);
    case (m)
      MODE_FIQ: bank_of = BANK_W'(1);
      MODE_IRQ: bank_of = BANK_W'(2);
      MODE_SVC: bank_of = BANK_W'(3);
      MODE_ABT: bank_of = BANK_W'(4);
      MODE_UND: bank_of = BANK_W'(5);
      MODE_MON: bank_of = BANK_W'(6);
      MODE_HYP: bank_of = BANK_W'(7);
      default:  bank_of = BANK_W'(0);
    endcase
  endfunction

  function automatic logic known_mode(input logic [4:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_MON,
      MODE_ABT, MODE_HYP, MODE_UND, MODE_SYS: known_mode = 1'b1;
      default: known_mode = 1'b0;
    endcase
  endfunction

  function automatic logic is_hi_reg(input logic [4:0] r);
    is_hi_reg = (r >= RN_HI_LO) && (r <= RN_HI_HI);
  endfunction

endpackage

// File: rtl/bru_access_check.sv
module bru_access_check
  import bru_pkg::*;
(
  input  logic [4:0] cur_mode,
  input  logic [4:0] tgt_mode,
  input  logic [4:0] reg_num,
  output logic       access_ok
);

  logic tgt_usr, tgt_hyp;
  assign tgt_usr = (tgt_mode == MODE_USR);
  assign tgt_hyp = (tgt_mode == MODE_HYP);

  always_comb begin
    access_ok = known_mode(tgt_mode);
    if (cur_mode == tgt_mode) access_ok = 1'b0;
    if (is_hi_reg(reg_num)) begin
      if (!tgt_usr && tgt_mode != MODE_FIQ) access_ok = 1'b0;
      if (tgt_usr && cur_mode != MODE_FIQ)  access_ok = 1'b0;
    end else if (reg_num == RN_SP) begin
      if (tgt_usr && cur_mode == MODE_SYS) access_ok = 1'b0;
    end else if (reg_num == RN_LR) begin
      if (tgt_usr && (cur_mode == MODE_HYP || cur_mode == MODE_SYS))
        access_ok = 1'b0;
    end else if (reg_num == RN_SPSR) begin
      if (tgt_usr || tgt_mode == MODE_SYS) access_ok = 1'b0;
    end else if (reg_num == RN_ELR) begin
      if (!tgt_hyp) access_ok = 1'b0;
      else if (cur_mode != MODE_HYP && cur_mode != MODE_MON) access_ok = 1'b0;
    end else begin
      access_ok = 1'b0;
    end
    if (tgt_hyp && reg_num != RN_ELR && cur_mode != MODE_MON) access_ok = 1'b0;
  end

endmodule

// File: rtl/bru_bank_store.sv
module bru_bank_store
  import bru_pkg::*;
#(
  parameter int DW   = 32,
  parameter int HI_N = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [4:0]    tgt_mode,
  input  logic [4:0]    reg_num,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int HI_IW = (HI_N > 1) ? $clog2(HI_N) : 1;

  logic [DW-1:0] hi_usr_q [HI_N];
  logic [DW-1:0] hi_fiq_q [HI_N];
  logic [DW-1:0] sp_q     [NBANK];
  logic [DW-1:0] lr_q     [NBANK];
  logic [DW-1:0] spsr_q   [NBANK];
  logic [DW-1:0] elr_q;

  logic [BANK_W-1:0] bank;
  logic [HI_IW-1:0]  hi_idx;
  logic [4:0]        hi_off;
  logic              tgt_fiq;

  assign bank    = bank_of(tgt_mode);
  assign hi_off  = reg_num - RN_HI_LO;
  assign hi_idx  = hi_off[HI_IW-1:0];
  assign tgt_fiq = (tgt_mode == MODE_FIQ);

  logic [NBANK-1:0] sp_we, lr_we, spsr_we;
  logic [HI_N-1:0]  usr_we, fiq_we;
  logic             elr_we;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank_we
    assign sp_we[b]   = we && reg_num == RN_SP   && bank == BANK_W'(b);
    assign lr_we[b]   = we && reg_num == RN_LR   && bank == BANK_W'(b);
    assign spsr_we[b] = we && reg_num == RN_SPSR && bank == BANK_W'(b);
  end

  for (genvar i = 0; i < HI_N; i++) begin : g_hi_we
    assign usr_we[i] = we && is_hi_reg(reg_num) && !tgt_fiq && hi_idx == HI_IW'(i);
    assign fiq_we[i] = we && is_hi_reg(reg_num) &&  tgt_fiq && hi_idx == HI_IW'(i);
  end

  assign elr_we = we && reg_num == RN_ELR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        sp_q[b]   <= '0;
        lr_q[b]   <= '0;
        spsr_q[b] <= '0;
      end
      for (int i = 0; i < HI_N; i++) begin
        hi_usr_q[i] <= '0;
        hi_fiq_q[i] <= '0;
      end
      elr_q <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (sp_we[b])   sp_q[b]   <= wdata;
        if (lr_we[b])   lr_q[b]   <= wdata;
        if (spsr_we[b]) spsr_q[b] <= wdata;
      end
      for (int i = 0; i < HI_N; i++) begin
        if (usr_we[i]) hi_usr_q[i] <= wdata;
        if (fiq_we[i]) hi_fiq_q[i] <= wdata;
      end
      if (elr_we) elr_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (is_hi_reg(reg_num)) begin
      for (int i = 0; i < HI_N; i++)
        if (hi_idx == HI_IW'(i)) rdata = tgt_fiq ? hi_fiq_q[i] : hi_usr_q[i];
    end else begin
      case (reg_num)
        RN_SP:   rdata = sp_q[bank];
        RN_LR:   rdata = lr_q[bank];
        RN_SPSR: rdata = spsr_q[bank];
        RN_ELR:  rdata = elr_q;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/banked_reg_unit.sv
module banked_reg_unit
  import bru_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    cur_mode,
  input  logic [4:0]    tgt_mode,
  input  logic [4:0]    reg_num,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          undef_pulse
);

  localparam int HI_N = int'(RN_HI_HI) - int'(RN_HI_LO) + 1;

  logic          access_ok;
  logic          strobe;
  logic          store_we;
  logic [DW-1:0] raw_rdata;

  bru_access_check u_check (
    .cur_mode  (cur_mode),
    .tgt_mode  (tgt_mode),
    .reg_num   (reg_num),
    .access_ok (access_ok)
  );

  assign strobe   = wr_en | rd_en;
  assign store_we = wr_en & access_ok;

  bru_bank_store #(.DW(DW), .HI_N(HI_N)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (store_we),
    .tgt_mode (tgt_mode),
    .reg_num  (reg_num),
    .wdata    (wr_data),
    .rdata    (raw_rdata)
  );

  assign undef_pulse = strobe & ~access_ok;
  assign rd_data     = (rd_en & access_ok) ? raw_rdata : '0;

endmodule

// File: rtl/bru_checker.sv
module bru_checker
  import bru_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    cur_mode,
  input logic [4:0]    tgt_mode,
  input logic [4:0]    reg_num,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          undef_pulse,
  input logic          store_we
);

  AST_SAME_MODE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && cur_mode == tgt_mode) |-> undef_pulse); // R1

  AST_USR_HI_NEEDS_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && tgt_mode == MODE_USR && reg_num >= 5'd8 &&
     reg_num <= 5'd12 && cur_mode != MODE_FIQ) |-> undef_pulse); // R2

  AST_USR_SP_FROM_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && tgt_mode == MODE_USR && reg_num == 5'd13 &&
     cur_mode == MODE_SYS) |-> undef_pulse); // R3

  AST_HYP_NEEDS_MON: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && tgt_mode == MODE_HYP && reg_num != 5'd17 &&
     cur_mode != MODE_MON) |-> undef_pulse); // R4

  AST_BAD_REGNUM: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && (reg_num < 5'd8 || reg_num > 5'd17 || reg_num == 5'd15))
      |-> undef_pulse); // R5

  AST_FAULT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    undef_pulse |-> !store_we); // R9

  AST_FAULT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    undef_pulse |-> rd_data == '0); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |-> (!undef_pulse && rd_data == '0)); // R10

endmodule

bind banked_reg_unit bru_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cur_mode    (cur_mode),
  .tgt_mode    (tgt_mode),
  .reg_num     (reg_num),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .undef_pulse (undef_pulse),
  .store_we    (store_we)
);

// File: tb/banked_reg_unit_tb.sv
`timescale 1ns/1ps
module banked_reg_unit_tb;

  localparam logic [4:0] USR = 5'h10, FIQ = 5'h11, IRQ = 5'h12, SVC = 5'h13,
                         MON = 5'h16, ABT = 5'h17, HYP = 5'h1A, UND = 5'h1B,
                         SYS = 5'h1F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cur_mode = SVC, tgt_mode = USR, reg_num = 5'd13;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        undef_pulse;

  always #2.5 clk = ~clk;

  banked_reg_unit #(.DW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .tgt_mode(tgt_mode),
    .reg_num(reg_num), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rd_data(rd_data), .undef_pulse(undef_pulse)
  );

  typedef struct {
    logic [31:0] rd;
    logic        uf;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference storage keyed by mode code, User and System folded together
  logic [31:0] m_usr[5], m_fiq[5], m_sp[32], m_lr[32], m_spsr[32], m_elr;

  function automatic logic [4:0] fold(input logic [4:0] m);
    return (m == SYS) ? USR : m;
  endfunction

  function automatic bit legal(input logic [4:0] c, input logic [4:0] t,
                               input logic [4:0] r);
    bit known;
    known = (t == USR || t == FIQ || t == IRQ || t == SVC || t == MON ||
             t == ABT || t == HYP || t == UND || t == SYS);
    if (!known || c == t) return 0;
    case (r)
      5'd8, 5'd9, 5'd10, 5'd11, 5'd12: return (t == FIQ) || (t == USR && c == FIQ);
      5'd13: return (t == HYP) ? (c == MON) : !(t == USR && c == SYS);
      5'd14: return (t == HYP) ? (c == MON) : !(t == USR && (c == HYP || c == SYS));
      5'd16: return (t == HYP) ? (c == MON) : !(t == USR || t == SYS);
      5'd17: return (t == HYP) && (c == MON || c == HYP);
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] peek(input logic [4:0] t, input logic [4:0] r);
    case (r)
      5'd13: return m_sp[fold(t)];
      5'd14: return m_lr[fold(t)];
      5'd16: return m_spsr[fold(t)];
      5'd17: return m_elr;
      default: return (t == FIQ) ? m_fiq[r - 5'd8] : m_usr[r - 5'd8];
    endcase
  endfunction

  task automatic poke(input logic [4:0] t, input logic [4:0] r, input logic [31:0] v);
    case (r)
      5'd13: m_sp[fold(t)] = v;
      5'd14: m_lr[fold(t)] = v;
      5'd16: m_spsr[fold(t)] = v;
      5'd17: m_elr = v;
      default: if (t == FIQ) m_fiq[r - 5'd8] = v; else m_usr[r - 5'd8] = v;
    endcase
  endtask

  // Driver: one access per cycle, expected result pushed to the scoreboard
  task automatic acc(input logic [4:0] c, input logic [4:0] t, input logic [4:0] r,
                     input bit w, input bit rd, input logic [31:0] v, input string tag);
    exp_t e;
    bit ok;
    @(posedge clk);
    #1;
    cur_mode = c; tgt_mode = t; reg_num = r; wr_en = w; rd_en = rd; wr_data = v;
    ok = legal(c, t, r);
    e.uf  = (w || rd) && !ok;
    e.rd  = (rd && ok) ? peek(t, r) : 32'h0;
    e.tag = tag;
    q.push_back(e);
    if (w && ok) poke(t, r, v);
  endtask

  task automatic idle(input string tag);
    acc(SVC, USR, 5'd13, 1'b0, 1'b0, 32'h0, tag);
  endtask

  task automatic check(input bit good, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: samples mid-cycle, pops and compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(rd_data === e.rd, e.tag, "rd_data", rd_data, e.rd);
        check(undef_pulse === e.uf, e.tag, "undef", 32'(undef_pulse), 32'(e.uf));
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin m_usr[i] = '0; m_fiq[i] = '0; end
    for (int i = 0; i < 32; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_spsr[i] = '0; end
    m_elr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset contents
    acc(SVC, USR, 5'd13, 0, 1, 0, "R11_sp");
    acc(SVC, FIQ, 5'd9,  0, 1, 0, "R11_fiq_hi");
    acc(MON, HYP, 5'd17, 0, 1, 0, "R11_elr");
    idle("R10_idle");

    // R7: per-bank SP/LR, User and System share
    acc(SVC, IRQ, 5'd13, 1, 0, 32'hA1A1_0001, "R7_wr_irq_sp");
    acc(SVC, IRQ, 5'd14, 1, 0, 32'hA1A1_0002, "R7_wr_irq_lr");
    acc(SVC, IRQ, 5'd13, 0, 1, 0, "R7_rd_irq_sp");
    acc(SVC, IRQ, 5'd14, 0, 1, 0, "R7_rd_irq_lr");
    acc(SVC, ABT, 5'd13, 0, 1, 0, "R7_abt_apart");
    acc(SVC, USR, 5'd13, 1, 0, 32'hC0C0_1313, "R7_wr_usr_sp");
    acc(IRQ, SYS, 5'd13, 0, 1, 0, "R7_sys_alias");
    acc(UND, SYS, 5'd14, 1, 0, 32'h5151_1414, "R7_wr_sys_lr");
    acc(IRQ, USR, 5'd14, 0, 1, 0, "R7_usr_lr_alias");

    // R8: two copies of registers 8..12
    for (int r = 8; r <= 12; r++) begin
      acc(FIQ, USR, 5'(r), 1, 0, 32'h1000_0000 + 32'(r), "R8_wr_usr");
      acc(SVC, FIQ, 5'(r), 1, 0, 32'h2000_0000 + 32'(r), "R8_wr_fiq");
    end
    for (int r = 8; r <= 12; r++) begin
      acc(FIQ, USR, 5'(r), 0, 1, 0, "R8_rd_usr");
      acc(ABT, FIQ, 5'(r), 0, 1, 0, "R8_rd_fiq");
    end

    // R2 and R9: refused write to User high reg leaves it intact
    acc(SVC, USR, 5'd8, 1, 0, 32'hDEAD_BEEF, "R2_svc_wr_usr8");
    acc(IRQ, USR, 5'd11, 0, 1, 0, "R2_irq_rd_usr11");
    acc(FIQ, USR, 5'd8, 0, 1, 0, "R9_usr8_intact");

    // R3
    acc(SYS, USR, 5'd13, 0, 1, 0, "R3_sys_sp");
    acc(SYS, USR, 5'd14, 1, 0, 32'h0BAD_0BAD, "R3_sys_lr");
    acc(HYP, USR, 5'd14, 0, 1, 0, "R3_hyp_lr");
    acc(HYP, USR, 5'd13, 0, 1, 0, "R3_hyp_sp_ok");
    acc(SVC, USR, 5'd14, 0, 1, 0, "R9_usr_lr_intact");

    // R4 and R6: Hyp target
    acc(MON, HYP, 5'd17, 1, 0, 32'hE1E1_1717, "R4_mon_wr_elr");
    acc(MON, HYP, 5'd17, 0, 1, 0, "R6_rd_elr");
    acc(HYP, HYP, 5'd17, 0, 1, 0, "R1_hyp_elr_same");
    acc(SVC, HYP, 5'd17, 1, 0, 32'h0, "R4_svc_elr");
    acc(SVC, HYP, 5'd13, 1, 0, 32'h1234_5678, "R4_svc_hyp_sp");
    acc(MON, HYP, 5'd13, 0, 1, 0, "R9_hyp_sp_intact");
    acc(MON, HYP, 5'd16, 1, 0, 32'h0000_01DA, "R4_mon_wr_hyp_spsr");
    acc(MON, HYP, 5'd16, 0, 1, 0, "R6_rd_hyp_spsr");

    // R6 and R5: saved status per bank
    acc(SVC, IRQ, 5'd16, 1, 0, 32'h0000_00D2, "R6_wr_irq_spsr");
    acc(SVC, IRQ, 5'd16, 0, 1, 0, "R6_rd_irq_spsr");
    acc(SVC, ABT, 5'd16, 0, 1, 0, "R6_abt_spsr_apart");
    acc(SVC, USR, 5'd16, 0, 1, 0, "R5_usr_spsr");
    acc(SVC, SYS, 5'd16, 1, 0, 32'hFFFF_FFFF, "R5_sys_spsr");

    // R5: other excluded combinations
    acc(SVC, USR, 5'd7,  0, 1, 0, "R5_reg7");
    acc(SVC, USR, 5'd15, 0, 1, 0, "R5_reg15");
    acc(SVC, USR, 5'd18, 0, 1, 0, "R5_reg18");
    acc(FIQ, SVC, 5'd8,  1, 0, 32'h77, "R5_svc_hi");
    acc(SVC, MON, 5'd17, 0, 1, 0, "R5_elr_not_hyp");
    acc(SVC, 5'h05, 5'd13, 0, 1, 0, "R5_bad_mode");
    acc(MON, HYP, 5'd17, 0, 1, 0, "R9_elr_intact");

    // R1: same mode
    acc(SVC, SVC, 5'd13, 1, 0, 32'h99, "R1_svc_same");
    acc(FIQ, FIQ, 5'd10, 0, 1, 0, "R1_fiq_same");
    acc(ABT, SVC, 5'd13, 0, 1, 0, "R9_svc_sp_intact");

    // R10: read in the write cycle shows the old value, next cycle the new
    acc(SVC, UND, 5'd13, 1, 1, 32'h5EED_0010, "R10_rw_same_cycle");
    acc(SVC, UND, 5'd13, 0, 1, 0, "R10_after_edge");
    idle("R10_idle_end");

    repeat (3) @(posedge clk);
    finished = 1;
    finish_run();
  end

endmodule